// File: doc/BRIEF.md
# Four-Phase Integrator Sequencer

This block is the digital controller for a charge digitizer built around four integrators that take turns. A free-running 2-bit phase counter staggers the integrators by one clock period. In every period one integrator is being reset, one integrates, one waits for its range decision and one is digitized. Each period therefore yields one measurement and conversion never pauses. The block drives a one-hot strobe bus for each of the four stages. It samples four per-range overflow flags and picks the range to digitize. It steers the analog mux to that range during the digitize stage.

For each integration period the block gathers four fields into one 16-bit word: the 6-bit time code taken while the integrator was integrating, the 2-bit range exponent chosen one period later, the 6-bit mantissa returned by the ADC in the digitize period, and the 2-bit phase tag. The 40 MHz word then leaves on eight lanes at double data rate, two bits per lane per period.

Top module: `quad_phase_seq`

## Requirements
- R1: Each strobe bus is one-hot once its stage holds a real phase. The integrate strobe marks phase `t`, where `t` is the value of the phase counter. The reset strobe marks `t+1`, range select marks `t-1` and digitize marks `t-2`, all modulo 4. Range select stays all-zero for the first period after reset, and digitize stays all-zero for the first two.
- R2: The phase tag of the first word after reset is 0. Each following word carries the previous tag plus one, modulo 4.
- R3: The chosen exponent is the lowest index `i` whose overflow flag `ovf_i[i]` is 0. When all four flags are 1, the exponent is 3.
- R4: During the digitize period of a phase, `range_sel_o` holds the exponent chosen for that phase.
- R5: The word layout is mantissa in bits [15:10], exponent in [9:8], phase tag in [7:6] and time code in [5:0]. All four fields come from one integration period. The time code is sampled at the clock edge that closes the integrate period. The overflow flags are sampled at the edge that closes the select period. The mantissa is sampled at the edge that closes the digitize period. The word appears right after that last edge.
- R6: Reset is asynchronous and active-low. While it is asserted and until the third clock edge after its release, `word_o`, `lane_o` and `word_vld_o` are all zero.
- R7: While `clk_i` is high, lane `k` carries word bit `2k`. While `clk_i` is low, lane `k` carries word bit `2k+1`.
- R8: Once `word_vld_o` rises, it stays high and a new word arrives on every clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Period clock; one integration period per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ovf_i | input | 4 | Overflow flags per range for the phase in range select |
| mant_i | input | 6 | ADC mantissa for the phase being digitized |
| tdc_i | input | 6 | Time code for the phase currently integrating |
| rst_stb_o | output | 4 | One-hot reset strobe per phase |
| int_stb_o | output | 4 | One-hot integrate strobe per phase |
| rsel_stb_o | output | 4 | One-hot range-select strobe per phase |
| dig_stb_o | output | 4 | One-hot digitize strobe per phase |
| range_sel_o | output | 2 | Range steered to the ADC during digitize |
| word_o | output | 16 | Packed result word |
| word_vld_o | output | 1 | Result word holds a real measurement |
| lane_o | output | 8 | Double-data-rate output lanes |

## Verification
The hardest condition to reach from the ports is the alignment in R5. A time code, a flag set and a mantissa are presented in three different periods and must end up together in one word. With constant inputs, a misaligned stage would go unnoticed. The stimulus therefore gives each period its own distinct time code, flag pattern and mantissa. Three staggered streams feed these values in, so a field delayed by one cycle too many or too few lands beside the wrong neighbours. An asynchronous reset is also applied in the middle of a stream, to show that the tag restarts at 0 and that the pipeline refills with no stale word.

// File: rtl/qp_pkg.sv
package qp_pkg;
  localparam int N_PH   = 4;
  localparam int TAG_W  = $clog2(N_PH);
  localparam int N_RNG  = 4;
  localparam int EXP_W  = $clog2(N_RNG);
  localparam int MANT_W = 6;
  localparam int TDC_W  = 6;
  localparam int WORD_W = MANT_W + EXP_W + TAG_W + TDC_W;
  localparam int N_LANE = WORD_W / 2;
  localparam int FILL_W = 2;

  typedef struct packed {
    logic [MANT_W-1:0] mant;
    logic [EXP_W-1:0]  expo;
    logic [TAG_W-1:0]  tag;
    logic [TDC_W-1:0]  tcode;
  } word_t;
endpackage

// File: rtl/qp_phase_ctr.sv
module qp_phase_ctr import qp_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [TAG_W-1:0] tag_o,
  output logic             ld_o,
  output logic             vld_o,
  output logic [N_PH-1:0]  rst_stb_o,
  output logic [N_PH-1:0]  int_stb_o,
  output logic [N_PH-1:0]  rsel_stb_o,
  output logic [N_PH-1:0]  dig_stb_o
);
  logic [TAG_W-1:0]  cnt_q;
  logic [FILL_W-1:0] fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      fill_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (fill_q != {FILL_W{1'b1}}) fill_q <= fill_q + 1'b1;
    end
  end

  // fill_q counts edges since reset: select stage real after 1, digitize after 2
  logic sel_ok, dig_ok;
  assign sel_ok = fill_q >= FILL_W'(1);
  assign dig_ok = fill_q >= FILL_W'(2);
  assign ld_o   = dig_ok;
  assign vld_o  = fill_q == {FILL_W{1'b1}};
  assign tag_o  = cnt_q;

  for (genvar p = 0; p < N_PH; p++) begin : g_ph
    localparam logic [TAG_W-1:0] P_INT = TAG_W'(p);
    localparam logic [TAG_W-1:0] P_RST = TAG_W'((p + N_PH - 1) % N_PH);
    localparam logic [TAG_W-1:0] P_SEL = TAG_W'((p + 1) % N_PH);
    localparam logic [TAG_W-1:0] P_DIG = TAG_W'((p + 2) % N_PH);
    assign int_stb_o[p]  = cnt_q == P_INT;
    assign rst_stb_o[p]  = cnt_q == P_RST;
    assign rsel_stb_o[p] = sel_ok && (cnt_q == P_SEL);
    assign dig_stb_o[p]  = dig_ok && (cnt_q == P_DIG);
  end
endmodule

// File: rtl/qp_range_pick.sv
module qp_range_pick #(
  parameter int N     = 4,
  parameter int SEL_W = $clog2(N)
) (
  input  logic [N-1:0]     ovf_i,
  output logic [SEL_W-1:0] sel_o
);
  // lowest range with a clear overflow flag; top range if all saturated
  always_comb begin
    sel_o = SEL_W'(N - 1);
    for (int i = N - 1; i >= 0; i--) begin
      if (!ovf_i[i]) sel_o = SEL_W'(i);
    end
  end
endmodule

// File: rtl/qp_word_pipe.sv
module qp_word_pipe import qp_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [TDC_W-1:0]  tdc_i,
  input  logic [N_RNG-1:0]  ovf_i,
  input  logic [MANT_W-1:0] mant_i,
  output logic [EXP_W-1:0]  rsel_o,
  output word_t             word_o
);
  logic [TAG_W-1:0] tag_s1, tag_s2;
  logic [TDC_W-1:0] tdc_s1, tdc_s2;
  logic [EXP_W-1:0] exp_s2, exp_pick;

  qp_range_pick #(.N(N_RNG), .SEL_W(EXP_W)) u_pick (
    .ovf_i (ovf_i),
    .sel_o (exp_pick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_s1 <= '0;
      tdc_s1 <= '0;
      tag_s2 <= '0;
      tdc_s2 <= '0;
      exp_s2 <= '0;
      word_o <= '0;
    end else begin
      tag_s1 <= tag_i;
      tdc_s1 <= tdc_i;
      tag_s2 <= tag_s1;
      tdc_s2 <= tdc_s1;
      exp_s2 <= exp_pick;
      if (ld_i) begin
        word_o.mant  <= mant_i;
        word_o.expo  <= exp_s2;
        word_o.tag   <= tag_s2;
        word_o.tcode <= tdc_s2;
      end
    end
  end

  assign rsel_o = exp_s2;
endmodule

// File: rtl/qp_lane_ddr.sv
module qp_lane_ddr import qp_pkg::*; (
  input  logic              clk_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [N_LANE-1:0] lane_o
);
  logic [N_LANE-1:0] even_b, odd_b;

  for (genvar k = 0; k < N_LANE; k++) begin : g_ln
    assign even_b[k] = word_i[2*k];
    assign odd_b[k]  = word_i[2*k+1];
  end

  // high half of the period sends the even bit, low half the odd bit
  always_comb lane_o = clk_i ? even_b : odd_b;
endmodule

// File: rtl/quad_phase_seq.sv
module quad_phase_seq import qp_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_RNG-1:0]  ovf_i,
  input  logic [MANT_W-1:0] mant_i,
  input  logic [TDC_W-1:0]  tdc_i,
  output logic [N_PH-1:0]   rst_stb_o,
  output logic [N_PH-1:0]   int_stb_o,
  output logic [N_PH-1:0]   rsel_stb_o,
  output logic [N_PH-1:0]   dig_stb_o,
  output logic [EXP_W-1:0]  range_sel_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o,
  output logic [N_LANE-1:0] lane_o
);
  logic [TAG_W-1:0] tag;
  logic             ld;
  word_t            word;

  qp_phase_ctr u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tag_o      (tag),
    .ld_o       (ld),
    .vld_o      (word_vld_o),
    .rst_stb_o  (rst_stb_o),
    .int_stb_o  (int_stb_o),
    .rsel_stb_o (rsel_stb_o),
    .dig_stb_o  (dig_stb_o)
  );

  qp_word_pipe u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (ld),
    .tag_i  (tag),
    .tdc_i  (tdc_i),
    .ovf_i  (ovf_i),
    .mant_i (mant_i),
    .rsel_o (range_sel_o),
    .word_o (word)
  );

  assign word_o = word;

  qp_lane_ddr u_ddr (
    .clk_i  (clk_i),
    .word_i (word_o),
    .lane_o (lane_o)
  );
endmodule

// File: rtl/quad_phase_seq_chk.sv
module quad_phase_seq_chk import qp_pkg::*; (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_RNG-1:0]  ovf_i,
  input logic [N_PH-1:0]   int_stb_o,
  input logic [N_PH-1:0]   rsel_stb_o,
  input logic [WORD_W-1:0] word_o,
  input logic              word_vld_o
);
  word_t w;
  assign w = word_t'(word_o);

  assert_int_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(int_stb_o) == 1);

  assert_sel_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_stb_o != '0) |=> (rsel_stb_o == $past(int_stb_o)));

  assert_tag_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld_o && $past(word_vld_o)) |-> (w.tag == TAG_W'($past(w.tag) + 1'b1)));

  assert_all_over_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld_o && ($past(ovf_i, 2) == '1)) |-> (w.expo == EXP_W'(N_RNG - 1)));

  assert_lowest_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld_o && !$past(ovf_i[0], 2)) |-> (w.expo == '0));

  assert_idle_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_vld_o |-> (word_o == '0));

  assert_no_gap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |=> word_vld_o);
endmodule

bind quad_phase_seq quad_phase_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ovf_i      (ovf_i),
  .int_stb_o  (int_stb_o),
  .rsel_stb_o (rsel_stb_o),
  .word_o     (word_o),
  .word_vld_o (word_vld_o)
);

// File: tb/quad_phase_seq_bench.sv
module quad_phase_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ovf = '0;
  logic [5:0]  mant = '0;
  logic [5:0]  tdc = '0;
  logic [3:0]  rst_stb, int_stb, rsel_stb, dig_stb;
  logic [1:0]  rsel;
  logic [15:0] word;
  logic        vld;
  logic [7:0]  lane;

  int checks = 0;
  int errors = 0;

  logic [5:0] tv [64];
  logic [5:0] mv [64];
  logic [3:0] ov [64];

  always #4 clk = ~clk;

  quad_phase_seq u_quad_phase_seq (
    .clk_i(clk), .rst_ni(rst_n), .ovf_i(ovf), .mant_i(mant), .tdc_i(tdc),
    .rst_stb_o(rst_stb), .int_stb_o(int_stb), .rsel_stb_o(rsel_stb),
    .dig_stb_o(dig_stb), .range_sel_o(rsel), .word_o(word),
    .word_vld_o(vld), .lane_o(lane)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] ref_exp(input logic [3:0] f);
    if (!f[0]) return 2'd0;
    if (!f[1]) return 2'd1;
    if (!f[2]) return 2'd2;
    return 2'd3;
  endfunction

  function automatic logic [15:0] ref_word(input int k);
    return {mv[k], ref_exp(ov[k]), 2'(k % 4), tv[k]};
  endfunction

  function automatic logic [7:0] lanes_of(input logic [15:0] w, input bit odd);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[k] = odd ? w[2*k+1] : w[2*k];
    return r;
  endfunction

  // enters at a negedge, leaves with reset released at a negedge
  task automatic do_reset();
    rst_n = 1'b0;
    ovf = '0; mant = '0; tdc = '0;
    #1;
    check("R6 reset word", 32'(word), 32'h0);
    check("R6 reset vld", 32'(vld), 32'h0);
    check("R6 reset lanes", 32'(lane), 32'h0);
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_stream(input int cnt);
    for (int n = 0; n < cnt + 2; n++) begin
      if (n > 0) @(negedge clk);
      tdc  = (n < cnt) ? tv[n] : '0;
      ovf  = (n >= 1 && n - 1 < cnt) ? ov[n-1] : '0;
      mant = (n >= 2) ? mv[n-2] : '0;
      #1;
      check("R1 int strobe", 32'(int_stb), 32'(4'b1 << (n % 4)));
      check("R1 reset strobe", 32'(rst_stb), 32'(4'b1 << ((n + 1) % 4)));
      check("R1 select strobe", 32'(rsel_stb), n >= 1 ? 32'(4'b1 << ((n + 3) % 4)) : 32'h0);
      check("R1 digitize strobe", 32'(dig_stb), n >= 2 ? 32'(4'b1 << ((n + 2) % 4)) : 32'h0);
      if (n >= 2) check("R4 range steer", 32'(rsel), 32'(ref_exp(ov[n-2])));
      if (n >= 3) check("R7 odd lanes", 32'(lane), 32'(lanes_of(ref_word(n - 3), 1'b1)));
      @(posedge clk);
      #1;
      if (n >= 2) begin
        check("R5 R2 R3 word", 32'(word), 32'(ref_word(n - 2)));
        check("R8 valid held", 32'(vld), 32'h1);
        check("R7 even lanes", 32'(lane), 32'(lanes_of(ref_word(n - 2), 1'b0)));
      end else begin
        check("R6 word idle", 32'(word), 32'h0);
        check("R6 vld idle", 32'(vld), 32'h0);
      end
    end
  endtask

  task automatic t_basic();
    for (int i = 0; i < 64; i++) begin
      tv[i] = 6'(i * 5 + 3);
      mv[i] = 6'(i * 11 + 7);
      ov[i] = 4'((1 << (i % 5)) - 1);
    end
    @(negedge clk);
    do_reset();
    run_stream(12);
  endtask

  task automatic t_ranges();
    logic [3:0] pats [8] = '{4'b0000, 4'b0001, 4'b0011, 4'b0111,
                             4'b1111, 4'b0101, 4'b1010, 4'b1110};
    for (int i = 0; i < 16; i++) begin
      ov[i] = pats[i % 8];
      tv[i] = 6'(63 - i);
      mv[i] = 6'(i * 3);
    end
    @(negedge clk);
    do_reset();
    run_stream(16);
  endtask

  task automatic t_midreset();
    for (int i = 0; i < 64; i++) begin
      tv[i] = 6'(i ^ 6'h2a);
      mv[i] = 6'(i ^ 6'h15);
      ov[i] = 4'(i * 7);
    end
    @(negedge clk);
    do_reset();
    run_stream(6);
    #2;
    rst_n = 1'b0;
    #1;
    check("R6 async word", 32'(word), 32'h0);
    check("R6 async vld", 32'(vld), 32'h0);
    check("R6 async lanes", 32'(lane), 32'h0);
    @(negedge clk);
    do_reset();
    run_stream(9);
  endtask

  initial begin
    t_basic();
    t_ranges();
    t_midreset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule